// File: doc/BRIEF.md
# Paged Address Translation Table with Paired Invalidation

This block holds the virtual-page to physical-page translations for a 36-bit processor. Each virtual page has one 18-bit entry made of a valid flag, a writable flag and a 16-bit physical page number. A lookup presents a full virtual address (page index above a word offset). In the same cycle the block returns the physical address, built from the stored page number and the untouched offset, or it raises a page-failure flag. A fill port loads one translation. An invalidate port clears an even/odd pair of entries in a single cycle.

The storage has two shapes. Writes see it as half as many words of twice the width, so every write updates an even/odd pair. A single-entry fill therefore merges the new entry with the current value of its neighbour. Lookups see it as one entry per index. The full page index selects the entry directly, with no choice between two banks.

After reset a sequencer walks every pair and clears it. During this walk every lookup faults, and fills and invalidates are dropped. A debug mode, enabled at build time by a parameter and switched at run time by a pin, accepts a translation only at the exact virtual address that filled the entry. Every other address in that page then faults, so each new access exercises the failure path.

Top module: `pgxlt_table`

## Requirements
- R1: After reset is released, `busy` stays high for exactly NPAIR rising clock edges (256 by default) and then stays low. When it falls, every entry is invalid.
- R2: While `busy` is high, a lookup with `lk_vld` high raises `pfail`, and fills and invalidates presented in that time change no entry.
- R3: In normal mode, a fill accepted at a clock edge makes a read lookup in the following cycle of any address in that page return `pfail` low and `lk_pa` = {fill page number, lookup offset}, where the page index is `lk_va[17:9]` and the offset is `lk_va[8:0]`.
- R4: A lookup of an invalid entry raises `pfail` in the same cycle. `lk_pa` is zero whenever `pfail` is high or `lk_vld` is low.
- R5: A lookup with `lk_wr` high raises `pfail` when the entry was filled with `fl_wrt` low. A read lookup of the same entry succeeds.
- R6: A fill of one entry leaves the other entry of its even/odd pair (index with bit 0 inverted) unchanged.
- R7: An invalidate of pair k makes entries 2k and 2k+1 fault from the next cycle on, and leaves every other entry unchanged.
- R8: When a fill and an invalidate arrive in the same cycle, the invalidate takes effect and the fill is dropped.
- R9: With `dbg_mode` high, a lookup succeeds only when its full address equals the address of the most recent fill of that entry. Any other offset in the page raises `pfail`. With `dbg_mode` low the same entry translates at any offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_mode | input | 1 | Exact-address acceptance mode |
| lk_vld | input | 1 | Lookup request |
| lk_wr | input | 1 | Lookup is for a write access |
| lk_va | input | 18 | Lookup virtual address: page [17:9], offset [8:0] |
| lk_pa | output | 25 | Physical address {page number, offset}; zero on fault or when idle |
| pfail | output | 1 | Page failure for the current lookup |
| fl_vld | input | 1 | Fill request |
| fl_va | input | 18 | Virtual address that caused the fill |
| fl_ppn | input | 16 | Physical page number to store |
| fl_wrt | input | 1 | Writable flag to store |
| inv_vld | input | 1 | Invalidate request |
| inv_pair | input | 8 | Pair index; clears entries 2k and 2k+1 |
| busy | output | 1 | Post-reset clear in progress |

## Verification
The hardest situation to reach is a fill that lands right beside a live neighbour. A wrong merge shows only when the other half of the pair is later read back. The stimulus fills every entry in ascending order, so each odd fill overwrites the pair just after its even entry was written. A full sweep then compares every entry against a model held in the bench. Invalidates at the lowest, a middle and the highest pair, an invalidate colliding with a fill, and fills during the clear walk are each followed by another full sweep. The last sweeps run in debug mode at the recorded offset and at one word past it.

// File: rtl/pgxlt_pkg.sv
package pgxlt_pkg;
  // Operation granted to the single pair-wide write port in a cycle.
  typedef enum logic [1:0] {
    WOP_NONE  = 2'd0,
    WOP_CLEAR = 2'd1,
    WOP_INVAL = 2'd2,
    WOP_FILL  = 2'd3
  } wop_e;
endpackage

// File: rtl/pgxlt_ctrl.sv
module pgxlt_ctrl
  import pgxlt_pkg::*;
#(
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_vld,
  input  logic [PAGE_W-1:0] fl_page,
  input  logic              inv_vld,
  input  logic [PAGE_W-2:0] inv_pair,
  output wop_e              wop,
  output logic [PAGE_W-2:0] wpair,
  output logic              busy
);
  localparam int PAIR_W = PAGE_W - 1;

  logic [PAIR_W-1:0] clr_cnt_q, clr_cnt_d;
  logic              busy_q, busy_d;
  logic              clr_en;

  // clear sequencer next state
  always_comb begin
    clr_en    = busy_q;
    clr_cnt_d = clr_cnt_q + PAIR_W'(1);
    busy_d    = (clr_cnt_q != {PAIR_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_cnt_q <= '0;
      busy_q    <= 1'b1;
    end else if (clr_en) begin
      clr_cnt_q <= clr_cnt_d;
      busy_q    <= busy_d;
    end
  end

  // write-port arbitration: clear, then invalidate, then fill
  always_comb begin
    if (busy_q) begin
      wop   = WOP_CLEAR;
      wpair = clr_cnt_q;
    end else if (inv_vld) begin
      wop   = WOP_INVAL;
      wpair = inv_pair;
    end else if (fl_vld) begin
      wop   = WOP_FILL;
      wpair = fl_page[PAGE_W-1:1];
    end else begin
      wop   = WOP_NONE;
      wpair = fl_page[PAGE_W-1:1];
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/pgxlt_store.sv
module pgxlt_store #(
  parameter int PAGE_W = 9,
  parameter int ENT_W  = 18
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [PAGE_W-2:0]  wr_pair,
  input  logic [2*ENT_W-1:0] wr_word,
  input  logic [PAGE_W-1:0]  rd_idx,
  output logic [ENT_W-1:0]   rd_ent,
  input  logic [PAGE_W-1:0]  nb_idx,
  output logic [ENT_W-1:0]   nb_ent
);
  localparam int NENT = 1 << PAGE_W;

  // One entry per index on the read side; the write side covers an
  // even/odd pair, odd entry in the upper half of wr_word.
  logic [NENT-1:0][ENT_W-1:0] tbl;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tbl[{wr_pair, 1'b0}] <= wr_word[ENT_W-1:0];
      tbl[{wr_pair, 1'b1}] <= wr_word[2*ENT_W-1:ENT_W];
    end
  end

  assign rd_ent = tbl[rd_idx];
  assign nb_ent = tbl[nb_idx];
endmodule

// File: rtl/pgxlt_tag.sv
module pgxlt_tag #(
  parameter bit DBG_EN = 1'b1,
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [OFS_W-1:0]  wofs,
  input  logic [PAGE_W-1:0] ridx,
  input  logic [OFS_W-1:0]  rofs,
  output logic              hit
);
  localparam int NENT = 1 << PAGE_W;

  generate
    if (DBG_EN) begin : g_tags
      logic [NENT-1:0][OFS_W-1:0] ofs_tbl;
      always_ff @(posedge clk) begin
        if (we) ofs_tbl[widx] <= wofs;
      end
      assign hit = (ofs_tbl[ridx] == rofs);
    end else begin : g_notags
      assign hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/pgxlt_table.sv
module pgxlt_table
  import pgxlt_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 9,
  parameter int PPN_W  = 16,
  parameter bit DBG_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dbg_mode,
  input  logic                     lk_vld,
  input  logic                     lk_wr,
  input  logic [PAGE_W+OFS_W-1:0]  lk_va,
  output logic [PPN_W+OFS_W-1:0]   lk_pa,
  output logic                     pfail,
  input  logic                     fl_vld,
  input  logic [PAGE_W+OFS_W-1:0]  fl_va,
  input  logic [PPN_W-1:0]         fl_ppn,
  input  logic                     fl_wrt,
  input  logic                     inv_vld,
  input  logic [PAGE_W-2:0]        inv_pair,
  output logic                     busy
);
  localparam int VA_W  = PAGE_W + OFS_W;
  localparam int ENT_W = PPN_W + 2;
  localparam int V_BIT = ENT_W - 1;
  localparam int W_BIT = ENT_W - 2;

  wop_e               wop;
  logic [PAGE_W-2:0]  wpair;
  logic [PAGE_W-1:0]  fl_page, lk_page, nb_idx;
  logic [OFS_W-1:0]   lk_ofs;
  logic [ENT_W-1:0]   rd_ent, nb_ent, new_ent;
  logic [2*ENT_W-1:0] wr_word;
  logic               wr_en, tag_hit, chk_tag;

  assign fl_page = fl_va[VA_W-1:OFS_W];
  assign lk_page = lk_va[VA_W-1:OFS_W];
  assign lk_ofs  = lk_va[OFS_W-1:0];
  assign nb_idx  = {fl_page[PAGE_W-1:1], ~fl_page[0]};

  pgxlt_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_vld   (fl_vld),
    .fl_page  (fl_page),
    .inv_vld  (inv_vld),
    .inv_pair (inv_pair),
    .wop      (wop),
    .wpair    (wpair),
    .busy     (busy)
  );

  // pair word for the wide write port; fills merge the live neighbour
  always_comb begin
    new_ent = {1'b1, fl_wrt, fl_ppn};
    wr_en   = (wop != WOP_NONE);
    if (wop == WOP_FILL)
      wr_word = fl_page[0] ? {new_ent, nb_ent} : {nb_ent, new_ent};
    else
      wr_word = '0;
  end

  pgxlt_store #(.PAGE_W(PAGE_W), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_pair (wpair),
    .wr_word (wr_word),
    .rd_idx  (lk_page),
    .rd_ent  (rd_ent),
    .nb_idx  (nb_idx),
    .nb_ent  (nb_ent)
  );

  pgxlt_tag #(.DBG_EN(DBG_EN), .PAGE_W(PAGE_W), .OFS_W(OFS_W)) u_tag (
    .clk  (clk),
    .we   (wop == WOP_FILL),
    .widx (fl_page),
    .wofs (fl_va[OFS_W-1:0]),
    .ridx (lk_page),
    .rofs (lk_ofs),
    .hit  (tag_hit)
  );

  // fault decision
  always_comb begin
    chk_tag = DBG_EN && dbg_mode;
    pfail   = lk_vld && (busy || !rd_ent[V_BIT] ||
                         (lk_wr && !rd_ent[W_BIT]) ||
                         (chk_tag && !tag_hit));
    lk_pa   = (lk_vld && !pfail) ? {rd_ent[PPN_W-1:0], lk_ofs} : '0;
  end
endmodule

// File: rtl/pgxlt_sva.sv
module pgxlt_sva #(
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 9,
  parameter int PPN_W  = 16,
  parameter bit DBG_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dbg_mode,
  input logic                    lk_vld,
  input logic                    lk_wr,
  input logic [PAGE_W+OFS_W-1:0] lk_va,
  input logic [PPN_W+OFS_W-1:0]  lk_pa,
  input logic                    pfail,
  input logic                    fl_vld,
  input logic [PAGE_W+OFS_W-1:0] fl_va,
  input logic [PPN_W-1:0]        fl_ppn,
  input logic                    fl_wrt,
  input logic                    inv_vld,
  input logic [PAGE_W-2:0]       inv_pair,
  input logic                    busy
);
  localparam int VA_W  = PAGE_W + OFS_W;
  localparam int NPAIR = 1 << (PAGE_W - 1);

  logic [PAGE_W:0] ccnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ccnt <= '0;
    else if (busy) ccnt <= ccnt + 1'b1;
  end

  logic fill_go;
  assign fill_go = fl_vld && !inv_vld && !busy;

  a_r1_clear_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ccnt < (PAGE_W+1)'(NPAIR)));

  a_r1_clear_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ccnt == (PAGE_W+1)'(NPAIR)));

  a_r2_busy_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && lk_vld) |-> pfail);

  a_r3_fill_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> (!(lk_vld && !lk_wr && !dbg_mode &&
                   lk_va[VA_W-1:OFS_W] == $past(fl_va[VA_W-1:OFS_W])) ||
                 (!pfail && lk_pa == {$past(fl_ppn), lk_va[OFS_W-1:0]})));

  a_r5_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && !fl_wrt) |=> (!(lk_vld && lk_wr &&
                   lk_va[VA_W-1:OFS_W] == $past(fl_va[VA_W-1:OFS_W])) || pfail));

  a_r7_inval_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_vld && !busy) |=> (!(lk_vld &&
                   lk_va[VA_W-1:OFS_W+1] == $past(inv_pair)) || pfail));

  a_r9_exact_only: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && DBG_EN) |=> (!(lk_vld && dbg_mode &&
                   lk_va[VA_W-1:OFS_W] == $past(fl_va[VA_W-1:OFS_W]) &&
                   lk_va[OFS_W-1:0] != $past(fl_va[OFS_W-1:0])) || pfail));
endmodule

bind pgxlt_table pgxlt_sva #(
  .PAGE_W(PAGE_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .DBG_EN(DBG_EN)
) u_sva (.*);

// File: tb/tb_pgxlt_table.sv
module tb_pgxlt_table;
  localparam int PAGE_W = 9;
  localparam int OFS_W  = 9;
  localparam int PPN_W  = 16;
  localparam int NENT   = 1 << PAGE_W;
  localparam int NPAIR  = NENT / 2;
  localparam int VA_W   = PAGE_W + OFS_W;
  localparam int PA_W   = PPN_W + OFS_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              dbg_mode, lk_vld, lk_wr, fl_vld, fl_wrt, inv_vld;
  logic [VA_W-1:0]   lk_va, fl_va;
  logic [PPN_W-1:0]  fl_ppn;
  logic [PAGE_W-2:0] inv_pair;
  logic [PA_W-1:0]   lk_pa;
  logic              pfail, busy;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model of the table
  bit              m_v   [NENT];
  bit              m_w   [NENT];
  logic [PPN_W-1:0] m_ppn[NENT];
  logic [OFS_W-1:0] m_ofs[NENT];

  always #5 clk = ~clk;

  pgxlt_table #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .PPN_W(PPN_W), .DBG_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode),
    .lk_vld(lk_vld), .lk_wr(lk_wr), .lk_va(lk_va), .lk_pa(lk_pa), .pfail(pfail),
    .fl_vld(fl_vld), .fl_va(fl_va), .fl_ppn(fl_ppn), .fl_wrt(fl_wrt),
    .inv_vld(inv_vld), .inv_pair(inv_pair), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [PPN_W-1:0] ppn_of(input int p, input int salt);
    return PPN_W'((p * 37 + 5 + salt * 1013) & 16'hFFFF);
  endfunction

  task automatic do_fill(input int p, input logic [OFS_W-1:0] o, input logic [PPN_W-1:0] n, input bit w);
    @(negedge clk);
    fl_vld = 1'b1; fl_va = {PAGE_W'(p), o}; fl_ppn = n; fl_wrt = w;
    @(posedge clk); #1;
    fl_vld = 1'b0;
    m_v[p] = 1'b1; m_w[p] = w; m_ppn[p] = n; m_ofs[p] = o;
  endtask

  task automatic do_inval(input int k);
    @(negedge clk);
    inv_vld = 1'b1; inv_pair = (PAGE_W-1)'(k);
    @(posedge clk); #1;
    inv_vld = 1'b0;
    m_v[2*k] = 1'b0; m_v[2*k+1] = 1'b0;
  endtask

  // lookup one address, compare against model
  task automatic look(input int p, input logic [OFS_W-1:0] o, input bit wr, input string req);
    bit              ef;
    logic [PA_W-1:0] ep;
    @(negedge clk);
    lk_vld = 1'b1; lk_wr = wr; lk_va = {PAGE_W'(p), o};
    #1;
    ef = !m_v[p] || (wr && !m_w[p]) || (dbg_mode && o != m_ofs[p]);
    ep = ef ? '0 : {m_ppn[p], o};
    chk(pfail == ef && lk_pa == ep, req, {pfail, lk_pa}, {ef, ep});
  endtask

  task automatic sweep(input int mode, input string req);
    for (int p = 0; p < NENT; p++) begin
      case (mode)
        0: look(p, m_ofs[p] ^ 9'h0C3, 1'b0, req);
        1: look(p, m_ofs[p] ^ 9'h111, 1'b1, req);
        2: look(p, m_ofs[p], 1'b0, req);
        default: look(p, m_ofs[p] + 9'd1, 1'b0, req);
      endcase
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; dbg_mode = 1'b0; lk_vld = 1'b0; lk_wr = 1'b0; lk_va = '0;
    fl_vld = 1'b0; fl_va = '0; fl_ppn = '0; fl_wrt = 1'b0;
    inv_vld = 1'b0; inv_pair = '0;
    for (int p = 0; p < NENT; p++) begin
      m_v[p] = 1'b0; m_w[p] = 1'b0; m_ppn[p] = '0; m_ofs[p] = '0;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    rst_n = 1'b1;
    // R2: fill and invalidate held during the walk, lookup must fault
    fl_vld = 1'b1; fl_va = {9'd3, 9'd0}; fl_ppn = 16'hBEEF; fl_wrt = 1'b1;
    inv_vld = 1'b0; lk_vld = 1'b1; lk_wr = 1'b0; lk_va = {9'd3, 9'd0};
    #1;
    chk(pfail == 1'b1 && lk_pa == '0, "R2 fault while busy", {pfail, lk_pa}, {1'b1, 25'd0});
    n = 0;
    while (busy && n < 1000) begin
      @(posedge clk); #1;
      n++;
    end
    fl_vld = 1'b0;
    chk(n == NPAIR, "R1 clear length", n, NPAIR);
    // R1/R2/R4: everything invalid after clear, busy-time fill dropped
    sweep(0, "R1 R2 R4 all invalid after clear");
    @(negedge clk); lk_vld = 1'b0; #1;
    chk(pfail == 1'b0 && lk_pa == '0, "R4 idle outputs", {pfail, lk_pa}, 0);

    // R3 R6: fill every entry in ascending order (odd follows even in a pair)
    for (int p = 0; p < NENT; p++)
      do_fill(p, OFS_W'(p ^ 9'h1A5), ppn_of(p, 0), p[1]);
    sweep(0, "R3 R6 read any offset");
    sweep(1, "R5 write permission");

    // R7: pairs at both ends and the middle
    do_inval(0);
    do_inval(77);
    do_inval(NPAIR - 1);
    sweep(0, "R7 pair invalidate");

    // R6: refill one half of an invalidated pair; other half stays invalid
    do_fill(154, 9'h040, ppn_of(154, 1), 1'b1);
    look(155, 9'h000, 1'b0, "R6 neighbour stays invalid");
    look(154, 9'h1FF, 1'b0, "R3 refill");

    // R8: invalidate and fill together
    @(negedge clk);
    inv_vld = 1'b1; inv_pair = 8'd10;
    fl_vld = 1'b1; fl_va = {9'd40, 9'd7}; fl_ppn = 16'h1234; fl_wrt = 1'b1;
    @(posedge clk); #1;
    inv_vld = 1'b0; fl_vld = 1'b0;
    m_v[20] = 1'b0; m_v[21] = 1'b0;
    look(40, 9'd7, 1'b0, "R8 fill dropped");
    look(20, 9'd0, 1'b0, "R8 invalidate wins");
    sweep(0, "R8 table intact");

    // R9: debug exact-address mode
    @(negedge clk); dbg_mode = 1'b1;
    sweep(2, "R9 exact address accepted");
    sweep(3, "R9 other offset faults");
    @(negedge clk); dbg_mode = 1'b0;
    sweep(3, "R9 normal mode any offset");

    @(negedge clk); lk_vld = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule